// File: doc/BRIEF.md
# J1850 Message CRC Generator and Checker

This block produces and verifies the 8-bit cyclic check byte of J1850-style serial messages, one whole byte per clock. A frame opens with a start strobe, which also picks the direction. The message bytes follow, each qualified by a valid strobe. A frame-end strobe closes the frame. In transmit direction the block then presents the check byte to append after the last data byte. In receive direction the incoming check byte is fed in with the data, and the block compares the final remainder with the fixed residue that every intact frame leaves behind.

The remainder register starts each frame at all ones. It divides by x^8 + x^4 + x^3 + x^2 + 1 (0x1D) and takes in the data most significant bit first. The register-level symbol timing, arbitration and physical layer belong to the link controller around this block.

A small state machine sequences each frame through three states. IDLE is entered at reset, and bytes and frame-end strobes are ignored there. ACCUM is entered from any state on a start strobe; it folds each valid byte into the remainder and also takes a restart on a further start strobe. DONE is entered from ACCUM on a frame-end strobe; it holds the result and ignores everything except a start strobe, which leads back to ACCUM.

Top module: `frame_crc8_unit`

## Requirements
- R1: With the remainder preset to 0xFF, polynomial 0x1D and MSB-first feed, the transmit check byte for the ASCII bytes "123456789" is 0x4B, and for any message it equals the one's complement of the final remainder.
- R2: After a transmit frame-end, crc_valid_o is 1 and crc_o holds the check byte unchanged until the next start strobe.
- R3: A receive frame made of a message followed by its correct check byte ends with crc_o = 0xC4, crc_valid_o = 1 and crc_err_o = 0.
- R4: A receive frame whose final remainder differs from 0xC4 sets crc_err_o; any single flipped bit in such a frame does so.
- R5: crc_err_o is sticky: only a start strobe or reset clears it, and idle cycles, stray bytes and frame-end strobes leave it set.
- R6: A frame-end with fewer than 1 byte (transmit) or fewer than 2 bytes (receive) sets len_err_o, leaves crc_valid_o at 0 and does not set crc_err_o.
- R7: A start strobe clears crc_valid_o, crc_err_o, len_err_o and crc_o to 0, and it presets the remainder, even in mid-frame. A byte or frame-end in the same cycle as a start strobe is dropped.
- R8: One byte is absorbed on every clock with valid_i high. A byte presented in the same cycle as the frame-end strobe is part of the frame.
- R9: Outside an open frame (IDLE or DONE), valid bytes and frame-end strobes change no output.
- R10: Synchronous reset gives crc_o = 0x00 with crc_valid_o, crc_err_o and len_err_o all 0, and it returns the machine to IDLE with the remainder at 0xFF.
- R11: dir_i is sampled with the start strobe: 0 selects transmit, 1 selects receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Opens a frame and clears result and flags |
| dir_i | input | 1 | Direction taken at start: 0 transmit, 1 receive |
| valid_i | input | 1 | data_i carries a message byte this cycle |
| data_i | input | 8 | Message byte, MSB sent first |
| end_i | input | 1 | Closes the open frame |
| crc_o | output | 8 | Transmit: check byte; receive: final remainder |
| crc_valid_o | output | 1 | crc_o holds a finished result |
| crc_err_o | output | 1 | Receive remainder was not 0xC4 (sticky) |
| len_err_o | output | 1 | Frame closed below minimum length |

## Verification
The assertions assume that start_i, valid_i and end_i are sampled only at rising edges, and that reset is synchronous and held across at least one edge. They assume that start_i always wins over a byte or frame-end in the same cycle, and that the direction matters only in the cycle of a start strobe. The stimulus changes every input on the falling edge, so each strobe is stable around the edge that takes it. Start and frame-end are driven as single-cycle pulses. The bench also applies the corner orderings on purpose: start together with a byte, frame-end together with the last byte, start in mid-frame, and stray bytes after a frame has closed.

// File: rtl/frame_crc8_pkg.sv
package frame_crc8_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_DONE  = 2'd2
    } frm_state_e;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } frm_dir_e;

    typedef struct packed {
        logic     clear;
        logic     fin_ok;
        logic     fin_short;
        frm_dir_e dir;
    } frm_evt_t;

endpackage

// File: rtl/crc8_byte_step.sv
module crc8_byte_step #(
    parameter int              CRC_W = 8,
    parameter logic [CRC_W-1:0] POLY = 8'h1D
) (
    input  logic [CRC_W-1:0] rem_i,
    input  logic [CRC_W-1:0] byte_i,
    output logic [CRC_W-1:0] rem_o
);

    logic [CRC_W:0][CRC_W-1:0] chain;

    assign chain[0] = rem_i;

    generate
        for (genvar i = 0; i < CRC_W; i++) begin : g_bit
            logic fb;
            assign fb = chain[i][CRC_W-1] ^ byte_i[CRC_W-1-i];
            assign chain[i+1] = {chain[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    endgenerate

    assign rem_o = chain[CRC_W];

endmodule

// File: rtl/crc8_frame_ctrl.sv
module crc8_frame_ctrl
    import frame_crc8_pkg::*;
#(
    parameter int               CRC_W  = 8,
    parameter logic [CRC_W-1:0] INIT   = 8'hFF,
    parameter int               MIN_TX = 1,
    parameter int               MIN_RX = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             dir_i,
    input  logic             valid_i,
    input  logic             end_i,
    input  logic [CRC_W-1:0] rem_nx_i,
    output logic [CRC_W-1:0] rem_q,
    output logic [CRC_W-1:0] rem_final,
    output frm_evt_t         evt
);

    localparam int CNT_MAX = (MIN_RX > MIN_TX) ? MIN_RX : MIN_TX;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    frm_state_e        state_q, state_d;
    frm_dir_e          dir_q;
    logic [CNT_W-1:0]  cnt_q, cnt_sel;
    logic              take, finishing, long_enough;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_ACCUM;
            ST_ACCUM: begin
                if (start_i)    state_d = ST_ACCUM;
                else if (end_i) state_d = ST_DONE;
            end
            ST_DONE:  if (start_i) state_d = ST_ACCUM;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        take      = (state_q == ST_ACCUM) && valid_i && !start_i;
        finishing = (state_q == ST_ACCUM) && end_i && !start_i;
        rem_final = take ? rem_nx_i : rem_q;
        cnt_sel   = cnt_q;
        if (take && (cnt_q != CNT_W'(CNT_MAX))) cnt_sel = cnt_q + 1'b1;
        if (dir_q == DIR_RX) long_enough = (cnt_sel >= CNT_W'(MIN_RX));
        else                 long_enough = (cnt_sel >= CNT_W'(MIN_TX));
        evt.clear     = start_i;
        evt.fin_ok    = finishing && long_enough;
        evt.fin_short = finishing && !long_enough;
        evt.dir       = dir_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= INIT;
            cnt_q <= '0;
            dir_q <= DIR_TX;
        end else if (start_i) begin
            rem_q <= INIT;
            cnt_q <= '0;
            dir_q <= frm_dir_e'(dir_i);
        end else if (take) begin
            rem_q <= rem_nx_i;
            cnt_q <= cnt_sel;
        end
    end

    assert_event_excl_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.clear, evt.fin_ok, evt.fin_short}));

    assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_ACCUM) && !start_i |=> $stable(rem_q));

    assert_close_to_done_R2: assert property (@(posedge clk) disable iff (rst)
        (evt.fin_ok || evt.fin_short) |=> (state_q == ST_DONE));

endmodule

// File: rtl/crc8_result_reg.sv
module crc8_result_reg
    import frame_crc8_pkg::*;
#(
    parameter int               CRC_W   = 8,
    parameter logic [CRC_W-1:0] RESIDUE = 8'hC4
) (
    input  logic             clk,
    input  logic             rst,
    input  frm_evt_t         evt,
    input  logic [CRC_W-1:0] rem_final,
    output logic [CRC_W-1:0] crc_o,
    output logic             crc_valid_o,
    output logic             crc_err_o,
    output logic             len_err_o
);

    always_ff @(posedge clk) begin
        if (rst || evt.clear) begin
            crc_o       <= '0;
            crc_valid_o <= 1'b0;
            crc_err_o   <= 1'b0;
            len_err_o   <= 1'b0;
        end else if (evt.fin_ok) begin
            crc_valid_o <= 1'b1;
            if (evt.dir == DIR_TX) begin
                crc_o <= ~rem_final;
            end else begin
                crc_o     <= rem_final;
                crc_err_o <= (rem_final != RESIDUE);
            end
        end else if (evt.fin_short) begin
            len_err_o <= 1'b1;
        end
    end

    assert_len_excl_R6: assert property (@(posedge clk) disable iff (rst)
        len_err_o |-> (!crc_valid_o && !crc_err_o));

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        crc_err_o && !evt.clear |=> crc_err_o);

    assert_start_clears_R7: assert property (@(posedge clk) disable iff (rst)
        evt.clear |=> (!crc_valid_o && !crc_err_o && !len_err_o));

    assert_result_hold_R2: assert property (@(posedge clk) disable iff (rst)
        crc_valid_o && !evt.clear |=> (crc_valid_o && $stable(crc_o)));

    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (!crc_valid_o && !crc_err_o && !len_err_o && (crc_o == '0)));

endmodule

// File: rtl/frame_crc8_unit.sv
module frame_crc8_unit
    import frame_crc8_pkg::*;
#(
    parameter int         CRC_W   = 8,
    parameter logic [7:0] POLY    = 8'h1D,
    parameter logic [7:0] INIT    = 8'hFF,
    parameter logic [7:0] RESIDUE = 8'hC4,
    parameter int         MIN_TX  = 1,
    parameter int         MIN_RX  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       dir_i,
    input  logic       valid_i,
    input  logic [7:0] data_i,
    input  logic       end_i,
    output logic [7:0] crc_o,
    output logic       crc_valid_o,
    output logic       crc_err_o,
    output logic       len_err_o
);

    logic [CRC_W-1:0] rem_q, rem_nx, rem_final;
    frm_evt_t         evt;

    crc8_byte_step #(.CRC_W(CRC_W), .POLY(POLY)) u_step (
        .rem_i  (rem_q),
        .byte_i (data_i),
        .rem_o  (rem_nx)
    );

    crc8_frame_ctrl #(
        .CRC_W(CRC_W), .INIT(INIT), .MIN_TX(MIN_TX), .MIN_RX(MIN_RX)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .dir_i     (dir_i),
        .valid_i   (valid_i),
        .end_i     (end_i),
        .rem_nx_i  (rem_nx),
        .rem_q     (rem_q),
        .rem_final (rem_final),
        .evt       (evt)
    );

    crc8_result_reg #(.CRC_W(CRC_W), .RESIDUE(RESIDUE)) u_res (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .rem_final   (rem_final),
        .crc_o       (crc_o),
        .crc_valid_o (crc_valid_o),
        .crc_err_o   (crc_err_o),
        .len_err_o   (len_err_o)
    );

endmodule

// File: tb/frame_crc8_unit_tb.sv
module frame_crc8_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_s = 1'b0, dir_s = 1'b0, valid_s = 1'b0, end_s = 1'b0;
    logic [7:0] data_s = 8'h00;
    logic [7:0] crc_w;
    logic       vld_w, err_w, len_w;

    int checks = 0;
    int errors = 0;
    bit reported = 0;

    logic [7:0] msg [0:15];

    localparam int NV = 6;
    localparam logic [3:0]  V_LEN [0:NV-1] = '{4'd9, 4'd1, 4'd1, 4'd2, 4'd4, 4'd3};
    localparam logic [71:0] V_MSG [0:NV-1] = '{
        72'h313233343536373839, 72'h000000000000000000, 72'hFF0000000000000000,
        72'h5AA500000000000000, 72'hDEADBEEF0000000000, 72'h010203000000000000};
    localparam logic        V_HAS [0:NV-1] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic [7:0]  V_EXP [0:NV-1] = '{8'h4B, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};

    always #4 clk = ~clk;

    frame_crc8_unit dut_i (
        .clk(clk), .rst(rst), .start_i(start_s), .dir_i(dir_s), .valid_i(valid_s),
        .data_i(data_s), .end_i(end_s), .crc_o(crc_w), .crc_valid_o(vld_w),
        .crc_err_o(err_w), .len_err_o(len_w)
    );

    function automatic logic [7:0] ref_check(input int n);
        logic [7:0] r = 8'hFF;
        for (int k = 0; k < n; k++) begin
            for (int b = 7; b >= 0; b--) begin
                logic top;
                top = r[7] ^ msg[k][b];
                r = r << 1;
                if (top) r = r ^ 8'h1D;
            end
        end
        return ~r;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    task automatic run_frame(input logic dir, input int n, input bit end_on_last);
        @(negedge clk); start_s = 1'b1; dir_s = dir;
        @(negedge clk); start_s = 1'b0; dir_s = 1'b0;
        for (int k = 0; k < n; k++) begin
            valid_s = 1'b1; data_s = msg[k];
            if (end_on_last && k == n - 1) end_s = 1'b1;
            @(negedge clk);
        end
        valid_s = 1'b0;
        if (!end_on_last || n == 0) begin
            end_s = 1'b1;
            @(negedge clk);
        end
        end_s = 1'b0;
    endtask

    task automatic load_row(input int r);
        for (int k = 0; k < 9; k++) msg[k] = V_MSG[r][71-8*k -: 8];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] exp_c, held;
        int n, pos;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10 crc", crc_w, 8'h00);
        chk("R10 flags", {5'd0, vld_w, err_w, len_w}, 8'h00);

        for (int r = 0; r < NV; r++) begin
            load_row(r);
            n = int'(V_LEN[r]);
            exp_c = V_HAS[r] ? V_EXP[r] : ref_check(n);
            run_frame(1'b0, n, 1'b0);
            chk("R1 tx check byte", crc_w, exp_c);
            chk("R2 R11 tx valid", {7'd0, vld_w}, 8'h01);
            msg[n] = crc_w;
            run_frame(1'b1, n + 1, 1'b0);
            chk("R3 rx residue", crc_w, 8'hC4);
            chk("R3 rx clean", {6'd0, err_w, vld_w}, 8'h01);
            pos = (r * 7 + 3) % (8 * (n + 1));
            msg[pos / 8] = msg[pos / 8] ^ (8'h80 >> (pos % 8));
            run_frame(1'b1, n + 1, 1'b0);
            chk("R4 single bit flip", {7'd0, err_w}, 8'h01);
        end

        // R5 and R9: stray traffic after a failed frame
        held = crc_w;
        repeat (3) @(negedge clk);
        valid_s = 1'b1; data_s = 8'h3C; @(negedge clk);
        valid_s = 1'b0; end_s = 1'b1;   @(negedge clk);
        end_s = 1'b0;
        chk("R5 error sticky", {7'd0, err_w}, 8'h01);
        chk("R9 crc unchanged", crc_w, held);
        start_s = 1'b1; @(negedge clk); start_s = 1'b0;
        chk("R5 R7 start clears", {5'd0, vld_w, err_w, len_w}, 8'h00);
        chk("R7 crc cleared", crc_w, 8'h00);

        // R6 length errors
        run_frame(1'b0, 0, 1'b0);
        chk("R6 tx empty", {5'd0, vld_w, err_w, len_w}, 8'h01);
        msg[0] = 8'h55;
        run_frame(1'b1, 1, 1'b0);
        chk("R6 rx one byte", {5'd0, vld_w, err_w, len_w}, 8'h01);

        // R8 frame-end together with the last byte
        load_row(0);
        run_frame(1'b0, 9, 1'b1);
        chk("R8 end with last byte", crc_w, 8'h4B);

        // R9 bytes after close do not disturb result
        valid_s = 1'b1; data_s = 8'hA7; @(negedge clk);
        end_s = 1'b1; @(negedge clk);
        valid_s = 1'b0; end_s = 1'b0;
        chk("R9 done ignores bytes", crc_w, 8'h4B);
        chk("R9 valid held", {7'd0, vld_w}, 8'h01);

        // R7 start in mid-frame, with a byte in the same cycle
        @(negedge clk); start_s = 1'b1; valid_s = 1'b1; data_s = 8'h11;
        @(negedge clk); start_s = 1'b0; data_s = 8'h22;
        @(negedge clk);
        start_s = 1'b1; data_s = 8'h99;
        @(negedge clk); start_s = 1'b0;
        for (int k = 0; k < 9; k++) begin data_s = msg[k]; @(negedge clk); end
        valid_s = 1'b0; end_s = 1'b1; @(negedge clk); end_s = 1'b0;
        chk("R7 restart drops old bytes", crc_w, 8'h4B);

        // R10 reset in mid-frame
        @(negedge clk); start_s = 1'b1; @(negedge clk); start_s = 1'b0;
        valid_s = 1'b1; data_s = 8'h77; @(negedge clk); valid_s = 1'b0;
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk("R10 reset mid-frame", {5'd0, vld_w, err_w, len_w}, 8'h00);
        end_s = 1'b1; @(negedge clk); end_s = 1'b0;
        chk("R9 R10 idle ignores end", {5'd0, vld_w, err_w, len_w}, 8'h00);

        summary();
        $finish;
    end

endmodule